// File: doc/BRIEF.md
# Prescaled 16-bit Event Timer

This block is a 16-bit up-counter that advances on one of two tick sources. The first is an internal strobe that fires once every four system clocks. The second is the rising edge of an external count pin. That pin is brought into the system clock domain through a two-flop synchroniser, and its edges are detected on the synchronised copy. A power-of-two divider sits between the chosen tick and the counter, and it can divide by 1, 2, 4 or 8. Software loads the counter one byte at a time. Software reads the live 16-bit value directly.

External counting must be armed before it counts. After reset, after any byte write, or after the block is disabled while the pin is high, a falling edge has to be seen while the block is enabled. Only then can a rising edge count. Any byte write also clears the hidden divider count. When the counter wraps from its all-ones value to zero, a sticky overflow flag is raised. The flag stays set until a one-cycle clear pulse arrives.

Top module: `evt_timer16`

## Requirements
- R1: After reset, `count_q` is 0x0000 and `ovf_flag` is 0.
- R2: With `src_ext`=0, `run_en`=1 and `div_sel`=0, the counter rises by exactly one every four clocks, so any 40-clock window adds 10.
- R3: `div_sel` values 0, 1, 2 and 3 divide the selected tick by 1, 2, 4 and 8. Starting from a cleared divider, 3·2^div_sel ticks give exactly 3 increments.
- R4: With `src_ext`=1 and the block armed, a rising edge on `ext_in` adds one. The new value appears on `count_q` after the third rising clock edge following the pin change, and not before.
- R5: After reset or any byte write, a rising edge on `ext_in` is ignored until a falling edge has been seen while `run_en`=1.
- R6: If `run_en` is low during any clock while the synchronised pin is high, the block is disarmed, and a later rising edge is ignored until a new falling edge is seen while enabled. Disabling while the pin is low keeps the block armed.
- R7: `wr_hi` loads `wr_data` into bits 15:8 and `wr_lo` loads it into bits 7:0. A write replaces any increment due in the same cycle and clears the divider count to zero.
- R8: A wrap from 0xFFFF to 0x0000 sets `ovf_flag` in the same cycle. The flag holds until `ovf_clr` is sampled high. A wrap and a clear in the same cycle leave the flag set.
- R9: While `run_en`=0, neither the counter nor the divider count changes, and ticks arriving then are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counting enable |
| src_ext | input | 1 | Tick source: 0 internal divide-by-4 strobe, 1 external pin |
| div_sel | input | 2 | Divider select: 0 ÷1, 1 ÷2, 2 ÷4, 3 ÷8 |
| ext_in | input | 1 | External count pin (asynchronous) |
| wr_hi | input | 1 | Load `wr_data` into the upper byte |
| wr_lo | input | 1 | Load `wr_data` into the lower byte |
| wr_data | input | 8 | Byte write data |
| ovf_clr | input | 1 | One-cycle clear of the overflow flag |
| count_q | output | 16 | Live counter value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Writes, internal-tick increments and the overflow flag all take effect one clock edge after the inputs are sampled. An external pin change takes three edges to show up: two synchroniser flops, and then the counter update. The bench drives inputs on falling edges and samples on falling edges. It checks the R4 latency by reading `count_q` after two edges, where it must not yet have changed, and again after three. The other directed checks count whole windows of 4·2^div_sel clocks, so they do not depend on the free-running phase of the internal strobe. A behavioural model with its own synchroniser history is compared against both outputs on every cycle.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int SEL_W = 2;
  localparam int PSC_W = (1 << SEL_W) - 1;

  typedef logic [SEL_W-1:0] div_sel_t;
  typedef logic [PSC_W-1:0] psc_cnt_t;

  typedef enum logic {
    TSRC_INT = 1'b0,
    TSRC_EXT = 1'b1
  } tick_src_t;

  // terminal divider count for a given select: 2^sel - 1
  function automatic psc_cnt_t psc_limit(input div_sel_t sel);
    return psc_cnt_t'((1 << sel) - 1);
  endfunction

  function automatic logic psc_at_limit(input psc_cnt_t pc, input div_sel_t sel);
    return (pc & psc_limit(sel)) == psc_limit(sel);
  endfunction

endpackage

// File: rtl/evt_int_tick.sv
module evt_int_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                      ph_q <= ph_q + 1'b1;
  end

  assign tick = (ph_q == PH_LAST);

  generate
    if (DIV > 1) begin : g_gap_chk
      AST_INT_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate

endmodule

// File: rtl/evt_ext_front.sv
module evt_ext_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic run_en,
  input  logic wr_any,
  output logic ext_tick
);
  logic [STAGES-1:0] sync_q;
  logic              synced;
  logic              prev_q;
  logic              rise_evt;
  logic              fall_evt;
  logic              armed_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], ext_in};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_in;
      end
    end
  endgenerate

  assign synced = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign rise_evt = synced & ~prev_q;
  assign fall_evt = ~synced & prev_q;

  // arming: cleared by write, or by sitting disabled with the pin high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed_q <= 1'b0;
    else if (wr_any)           armed_q <= 1'b0;
    else if (!run_en && synced) armed_q <= 1'b0;
    else if (run_en && fall_evt) armed_q <= 1'b1;
  end

  assign ext_tick = armed_q & rise_evt;

  AST_ARM_DROP_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !armed_q); // R5
  AST_ARM_DROP_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && synced) |=> !armed_q); // R6
  AST_ARM_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> ($past(run_en) && $past(prev_q) && !$past(synced))); // R5
  AST_EXT_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick); // R4

endmodule

// File: rtl/evt_prescale.sv
module evt_prescale
  import evt_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_en,
  input  logic     tick_in,
  input  logic     clr,
  input  div_sel_t div_sel,
  output logic     inc
);
  psc_cnt_t pc_q;
  logic     at_lim;
  logic     step;

  assign at_lim = psc_at_limit(pc_q, div_sel);
  assign step   = run_en & tick_in & ~clr;
  assign inc    = step & at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (clr)  pc_q <= '0;
    else if (step) pc_q <= at_lim ? '0 : pc_q + 1'b1;
  end

  AST_PSC_CLEARED_BY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pc_q == '0)); // R7
  AST_PSC_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr) |=> $stable(pc_q)); // R9
  AST_PSC_DIV1_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == '0 && run_en && tick_in && !clr) |-> inc); // R3

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int INT_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               src_ext,
  input  logic [1:0]         div_sel,
  input  logic               ext_in,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               ovf_clr,
  output logic [CNT_W-1:0]   count_q,
  output logic               ovf_flag
);
  localparam int HALF_W = CNT_W / 2;

  function automatic logic [CNT_W-1:0] load_halves(
    input logic [CNT_W-1:0]  cur,
    input logic [HALF_W-1:0] data,
    input logic              hi,
    input logic              lo
  );
    logic [CNT_W-1:0] r;
    r = cur;
    if (hi) r[CNT_W-1:HALF_W] = data;
    if (lo) r[HALF_W-1:0]     = data;
    return r;
  endfunction

  tick_src_t        src;
  logic             wr_any;
  logic             int_tick;
  logic             ext_tick;
  logic             tick_sel;
  logic             inc_evt;
  logic             ovf_evt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             flag_q;

  assign src    = tick_src_t'(src_ext);
  assign wr_any = wr_hi | wr_lo;

  evt_int_tick #(.DIV(INT_DIV)) u_int_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (int_tick)
  );

  evt_ext_front #(.STAGES(SYNC_STAGES)) u_ext_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_in  (ext_in),
    .run_en  (run_en),
    .wr_any  (wr_any),
    .ext_tick(ext_tick)
  );

  assign tick_sel = (src == TSRC_EXT) ? ext_tick : int_tick;

  evt_prescale u_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .tick_in(tick_sel),
    .clr    (wr_any),
    .div_sel(div_sel),
    .inc    (inc_evt)
  );

  assign ovf_evt = inc_evt & (cnt_q == '1);

  always_comb begin
    if (wr_any)       cnt_d = load_halves(cnt_q, wr_data, wr_hi, wr_lo);
    else if (inc_evt) cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (ovf_evt) flag_q <= 1'b1;
    else if (ovf_clr) flag_q <= 1'b0;
  end

  assign count_q  = cnt_q;
  assign ovf_flag = flag_q;

  AST_CNT_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_any) |=> $stable(count_q)); // R9
  AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && !wr_any) |=> (count_q == $past(count_q) + 1'b1)); // R2
  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag); // R8
  AST_OVF_WRAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (count_q == '0)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
  AST_WR_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (count_q[HALF_W-1:0] == $past(wr_data))); // R7
  AST_WR_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (count_q[CNT_W-1:HALF_W] == $past(wr_data))); // R7

endmodule

// File: tb/tb_evt_timer16.sv
module tb_evt_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        src_ext = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic        ext_in = 1'b0;
  logic        wr_hi = 1'b0;
  logic        wr_lo = 1'b0;
  logic [7:0]  wr_data = 8'd0;
  logic        ovf_clr = 1'b0;
  logic [15:0] count_q;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  evt_timer16 dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_ext(src_ext),
    .div_sel(div_sel), .ext_in(ext_in), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .ovf_clr(ovf_clr), .count_q(count_q), .ovf_flag(ovf_flag)
  );

  // ---------------- behavioural reference ----------------
  int m_cnt, m_pc, m_ph, m_arm, m_ovf;
  int hist[$] = '{0, 0, 0};

  always @(posedge clk or negedge rst_n) begin : ref_model
    int div, rise, fall, tick, inc, setf;
    if (!rst_n) begin
      m_cnt = 0; m_pc = 0; m_ph = 0; m_arm = 0; m_ovf = 0;
      hist = '{0, 0, 0};
    end else begin
      div  = 1 << div_sel;
      rise = (hist[1] == 1 && hist[2] == 0) ? 1 : 0;
      fall = (hist[1] == 0 && hist[2] == 1) ? 1 : 0;
      tick = src_ext ? (m_arm & rise) : ((m_ph == 3) ? 1 : 0);
      inc  = 0;
      setf = 0;
      if (wr_hi || wr_lo) m_pc = 0;
      else if (run_en && tick != 0) begin
        if (m_pc % div == div - 1) begin inc = 1; m_pc = 0; end
        else m_pc = (m_pc + 1) % 8;
      end
      if (wr_hi || wr_lo) m_arm = 0;
      else if (!run_en && hist[1] == 1) m_arm = 0;
      else if (run_en && fall == 1) m_arm = 1;
      if (wr_hi || wr_lo) begin
        if (wr_hi) m_cnt = (m_cnt % 256) + int'(wr_data) * 256;
        if (wr_lo) m_cnt = (m_cnt / 256) * 256 + int'(wr_data);
      end else if (inc == 1) begin
        if (m_cnt == 65535) begin m_cnt = 0; setf = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (setf == 1) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      m_ph = (m_ph + 1) % 4;
      hist.push_front(int'(ext_in));
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (int'(count_q) != m_cnt || int'(ovf_flag) != m_ovf) begin
        errors++;
        $display("FAIL R2 per-cycle model: count=%h flag=%0d expected count=%h flag=%0d",
                 count_q, ovf_flag, m_cnt[15:0], m_ovf);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_both(input logic [7:0] d);
    wr_hi = 1'b1; wr_lo = 1'b1; wr_data = d;
    step(1);
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic finish_run;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_wrap;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (count_q != 16'hFFFF) break;
    end
  endtask

  initial begin
    #3000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  // ---------------- directed stimulus ----------------
  initial begin : stim
    int c0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset count", int'(count_q), 0);
    chk("R1 reset flag", int'(ovf_flag), 0);

    // R2: internal strobe, divide by one
    run_en = 1'b1;
    step(1);
    c0 = int'(count_q);
    step(40);
    chk("R2 internal rate", int'(count_q), c0 + 10);

    // R3 and R7 (divider cleared by write)
    for (int s = 0; s < 4; s++) begin
      div_sel = 2'(s);
      step(13);
      write_both(8'h00);
      step(12 * (1 << s));
      chk("R3/R7 divide window", int'(count_q), 3);
    end

    // R9: freeze counter and divider while disabled
    div_sel = 2'd3;
    write_both(8'h00);
    step(48);
    chk("R3 div8 partial", int'(count_q), 1);
    run_en = 1'b0;
    step(50);
    chk("R9 frozen count", int'(count_q), 1);
    run_en = 1'b1;
    step(16);
    chk("R9 divider kept", int'(count_q), 2);

    // R7: byte loads and write-over-increment
    run_en = 1'b0;
    wr_hi = 1'b1; wr_data = 8'h12; step(1); wr_hi = 1'b0;
    wr_lo = 1'b1; wr_data = 8'h34; step(1); wr_lo = 1'b0;
    chk("R7 byte load", int'(count_q), 16'h1234);
    div_sel = 2'd0; run_en = 1'b1;
    wr_lo = 1'b1; wr_data = 8'h55;
    step(12);
    wr_lo = 1'b0;
    chk("R7 write wins", int'(count_q), 16'h1255);

    // R8: overflow flag
    run_en = 1'b0;
    write_both(8'hFF);
    run_en = 1'b1;
    wait_wrap();
    chk("R8 wrap value", int'(count_q), 0);
    chk("R8 flag set", int'(ovf_flag), 1);
    run_en = 1'b0;
    step(5);
    chk("R8 flag sticky", int'(ovf_flag), 1);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk("R8 flag cleared", int'(ovf_flag), 0);
    write_both(8'hFF);
    ovf_clr = 1'b1;
    run_en = 1'b1;
    wait_wrap();
    chk("R8 set beats clear", int'(ovf_flag), 1);
    step(1);
    chk("R8 clear next", int'(ovf_flag), 0);
    ovf_clr = 1'b0;

    // R4/R5: external counting with arming
    src_ext = 1'b1; div_sel = 2'd0; ext_in = 1'b0;
    write_both(8'h00);
    step(4);
    ext_in = 1'b1; step(4);
    chk("R5 rise after write ignored", int'(count_q), 0);
    ext_in = 1'b0; step(4);
    ext_in = 1'b1;
    step(2);
    chk("R4 not before third edge", int'(count_q), 0);
    step(1);
    chk("R4 third edge", int'(count_q), 1);
    step(3);
    ext_in = 1'b0; step(4);
    ext_in = 1'b1; step(4);
    chk("R4 second rise", int'(count_q), 2);

    // R6: disabled while high, re-enabled low
    run_en = 1'b0; step(3);
    ext_in = 1'b0; step(4);
    run_en = 1'b1; step(2);
    ext_in = 1'b1; step(4);
    chk("R6 rise ignored", int'(count_q), 2);
    ext_in = 1'b0; step(4);
    ext_in = 1'b1; step(4);
    chk("R6 rearmed", int'(count_q), 3);
    ext_in = 1'b0; step(4);
    run_en = 1'b0; step(3);
    run_en = 1'b1; step(1);
    ext_in = 1'b1; step(4);
    chk("R6 disabled low stays armed", int'(count_q), 4);

    step(2);
    finish_run();
  end

endmodule